// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Byte-Lane Writes

This block is a single-port synchronous static memory. Each word holds four byte lanes of nine bits: eight data bits and one parity bit. On every rising clock edge it captures the address, the write data and all control inputs in an input register. The access held in that register takes effect on the next rising edge. A write stores the selected lanes. A read loads the addressed word into an output register, so read data appears one clock after the address is captured.

Three write-control inputs decide which lanes a write touches. A global write stores every lane. Without it, a byte-write enable together with four lane selects picks the lanes. Every access is qualified by two chip enables, one active-low and one active-high. Deselection releases the output drivers on a two-clock delay, which lets pipelined read data drain. An asynchronous output enable gates only the drivers. A snooze input suspends new accesses and keeps the stored contents. The drivers are modelled as a data output `q_o` plus a drive flag `q_drive_o`. When the flag is 0, the data pins are high-impedance.

Top module: `pipe_sram`

## Requirements
- R1: While `rst_ni` is low, and until the first access after reset, `q_o` is 0 and `q_drive_o` is 0.
- R2: A selected non-write cycle captured at edge k loads the stored word at `addr_i` into `q_o` after edge k+1. If `oe_i` is 1, `q_drive_o` is 1 from then on.
- R3: When `gwrite_i` is 1 in a selected cycle, all 36 bits of `wdata_i` are stored, whatever `bwe_i` and `lane_sel_i` are.
- R4: When `gwrite_i` is 0 and `bwe_i` is 1, only the lanes with `lane_sel_i[l]`=1 are stored. Lane l covers bits [9l+8:9l], and bit 9l+8 is its parity bit. If no lane is enabled (`bwe_i`=0, or all selects 0), the cycle is a read and `lane_sel_i` has no effect.
- R5: A cycle is selected only when `ce_n_i`=0 and `ce_i`=1. An unselected cycle stores nothing and starts no read.
- R6: After the last read, each unselected cycle that follows keeps `q_o` unchanged. The drivers stay enabled through the second such cycle, and `q_drive_o` falls after the edge that completes the second unselected cycle.
- R7: A selected write captured at edge k turns `q_drive_o` off after edge k+1 and leaves `q_o` unchanged.
- R8: `oe_i`=0 forces `q_drive_o` to 0 at once, without a clock. It does not change the pipeline: when `oe_i` returns to 1, the drive state and `q_o` are as if it had never fallen.
- R9: A cycle captured with `snooze_i`=1 is treated as unselected, and the stored contents are retained. The first cycle captured with `snooze_i`=0 is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| ce_n_i | input | 1 | Chip enable, active low |
| ce_i | input | 1 | Chip enable, active high |
| gwrite_i | input | 1 | Global write, stores all lanes |
| bwe_i | input | 1 | Byte-write enable qualifying lane selects |
| lane_sel_i | input | LANES | Per-lane write select |
| wdata_i | input | LANES*LANE_W | Write data, lane l at bits [9l+8:9l] |
| oe_i | input | 1 | Asynchronous output enable |
| snooze_i | input | 1 | Reduced-power idle request |
| q_o | output | LANES*LANE_W | Registered read data |
| q_drive_o | output | 1 | Output drivers enabled (0 means high-impedance) |

## Verification
A write to an address can be followed at once by a read of the same address. Then, on one edge, the write commits while the read's address is captured. The bench provokes this by driving such back-to-back cycles and judges it by the read returning the new word. A second overlap is the drain of a deselect meeting a new access, or a snooze starting while an accepted write still sits in the input register. The scoreboard compares `q_o` and the drive flag after every edge against a reference that follows the requirements cycle by cycle.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/sram_wr_decode.sv
module sram_wr_decode #(
  parameter int LANES = 4
) (
  input  logic             gwrite_i,
  input  logic             bwe_i,
  input  logic [LANES-1:0] lane_sel_i,
  output logic [LANES-1:0] lane_we_o
);
  // global write wins; lane selects count only under bwe
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_we_o[l] = gwrite_i | (bwe_i & lane_sel_i[l]);
  end
endmodule

// File: rtl/sram_core.sv
module sram_core #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  lane_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (wr_i && lane_we_i[l]) mem[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q_o[l*LANE_W +: LANE_W] <= '0;
      else if (rd_i) q_o[l*LANE_W +: LANE_W] <= mem[addr_i];
    end
  end

  // R6 R7: output register only moves on a read
  a_r6_q_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(q_o));
endmodule

// File: rtl/sram_out_ctl.sv
module sram_out_ctl
  import pipe_sram_pkg::*;
#(
  parameter int HOLD = 2,
  localparam int CW  = $clog2(HOLD + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  op_e  op_i,
  input  logic oe_i,
  output logic drive_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (op_i == OP_READ)    cnt_q <= CW'(HOLD);
    else if (op_i == OP_WRITE)   cnt_q <= '0;
    else if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
  end

  assign drive_o = oe_i && (cnt_q != '0);

  a_r7_write_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_WRITE |=> !drive_o);
  a_r2_read_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_READ && oe_i) |=> (drive_o || !oe_i));
  a_r6_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_IDLE && $past(op_i == OP_READ) && oe_i) |=> (drive_o || !oe_i));
  always_comb begin
    if (rst_ni && !oe_i) a_r8_oe_gate: assert (!drive_o);
  end
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_n_i,
  input  logic              ce_i,
  input  logic              gwrite_i,
  input  logic              bwe_i,
  input  logic [LANES-1:0]  lane_sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              oe_i,
  input  logic              snooze_i,
  output logic [DATA_W-1:0] q_o,
  output logic              q_drive_o
);
  logic [LANES-1:0]  lane_we;
  logic              sel;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  lanes_q;
  logic [DATA_W-1:0] wdata_q;

  sram_wr_decode #(.LANES(LANES)) u_dec (
    .gwrite_i  (gwrite_i),
    .bwe_i     (bwe_i),
    .lane_sel_i(lane_sel_i),
    .lane_we_o (lane_we)
  );

  assign sel = !ce_n_i && ce_i && !snooze_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_IDLE;
      addr_q  <= '0;
      lanes_q <= '0;
      wdata_q <= '0;
    end else begin
      op_q    <= !sel ? OP_IDLE : ((|lane_we) ? OP_WRITE : OP_READ);
      addr_q  <= addr_i;
      lanes_q <= lane_we;
      wdata_q <= wdata_i;
    end
  end

  sram_core #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (op_q == OP_WRITE),
    .rd_i     (op_q == OP_READ),
    .addr_i   (addr_q),
    .lane_we_i(lanes_q),
    .wdata_i  (wdata_q),
    .q_o      (q_o)
  );

  sram_out_ctl #(.HOLD(2)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op_q),
    .oe_i   (oe_i),
    .drive_o(q_drive_o)
  );

  a_r9_snooze_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snooze_i |=> op_q == OP_IDLE);
  a_r5_ce_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_n_i || !ce_i) |=> op_q == OP_IDLE);
  a_r3_gw_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && gwrite_i) |=> op_q == OP_WRITE);
endmodule

// File: tb/tb_pipe_sram.sv
module tb_pipe_sram;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic [7:0]  addr_i = '0;
  logic        ce_n_i = 1, ce_i = 0, gwrite_i = 0, bwe_i = 0;
  logic [3:0]  lane_sel_i = '0;
  logic [35:0] wdata_i = '0;
  logic        oe_i = 1, snooze_i = 0;
  logic [35:0] q_o;
  logic        q_drive_o;

  pipe_sram dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct { logic [35:0] q; logic drv; string tag; } item_t;
  item_t sb[$];
  int n_tests = 0, n_fail = 0;

  // reference state per requirements
  logic [35:0] m_mem [256];
  logic [35:0] m_q = '0;
  int          m_hold = 0;
  logic        s_act = 0, s_wr = 0;
  logic [3:0]  s_lanes = '0;
  logic [7:0]  s_addr = '0;
  logic [35:0] s_data = '0;

  task automatic cyc(input string tag, input logic cen, input logic ce, input logic gw,
                     input logic bwe, input logic [3:0] lsel, input logic [7:0] a,
                     input logic [35:0] d, input logic oe, input logic snz);
    item_t it;
    logic [3:0] we;
    @(negedge clk_i);
    ce_n_i = cen; ce_i = ce; gwrite_i = gw; bwe_i = bwe; lane_sel_i = lsel;
    addr_i = a; wdata_i = d; oe_i = oe; snooze_i = snz;
    if (s_act && s_wr) begin
      for (int l = 0; l < 4; l++)
        if (s_lanes[l]) m_mem[s_addr][l*9 +: 9] = s_data[l*9 +: 9];
      m_hold = 0;
    end else if (s_act) begin
      m_q = m_mem[s_addr];
      m_hold = 2;
    end else if (m_hold > 0) m_hold--;
    we = gw ? 4'hF : (bwe ? lsel : 4'h0);
    s_act = !cen && ce && !snz;
    s_wr = (we != 0);
    s_lanes = we; s_addr = a; s_data = d;
    it.q = m_q; it.drv = oe && (m_hold > 0); it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr_all(input string tag, input logic [7:0] a, input logic [35:0] d);
    cyc(tag, 0, 1, 1, 0, 4'h0, a, d, 1, 0);
  endtask
  task automatic rd(input string tag, input logic [7:0] a);
    cyc(tag, 0, 1, 0, 0, 4'h0, a, '0, 1, 0);
  endtask
  task automatic idle(input string tag);
    cyc(tag, 1, 1, 0, 0, 4'h0, 8'h00, '0, 1, 0);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk_i);
      #2;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        n_tests++;
        if (q_o !== it.q || q_drive_o !== it.drv) begin
          n_fail++;
          $display("FAIL %s: q=%h drv=%b expected q=%h drv=%b",
                   it.tag, q_o, q_drive_o, it.q, it.drv);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    n_tests++;
    if (q_o !== '0 || q_drive_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: q=%h drv=%b expected q=0 drv=0", q_o, q_drive_o);
    end
    rst_ni = 1;
    n_tests++;
    if (q_o !== '0 || q_drive_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: q=%h drv=%b expected q=0 drv=0", q_o, q_drive_o);
    end
    idle("R1");
    // R3: global write, then global write overriding bwe/lane selects
    wr_all("R3", 8'h05, 36'h9_1234_5678);
    cyc("R3", 0, 1, 1, 1, 4'h1, 8'h06, 36'h3_CAFE_F00D, 1, 0);
    wr_all("R3", 8'h07, 36'hA_5A5A_5A5A);
    // R2: reads back to back
    rd("R2", 8'h05);
    rd("R2", 8'h06);
    rd("R2", 8'h07);
    // R4: byte write of lanes 0 and 2, then bwe=0 with selects is a read
    cyc("R4", 0, 1, 0, 1, 4'h5, 8'h05, 36'hF_FFFF_FFFF, 1, 0);
    rd("R4", 8'h05);
    cyc("R4", 0, 1, 0, 0, 4'hF, 8'h06, 36'h0_0000_0000, 1, 0);
    cyc("R4", 0, 1, 0, 1, 4'h0, 8'h06, 36'h0_0000_0000, 1, 0);
    cyc("R4", 0, 1, 0, 1, 4'h8, 8'h06, 36'h1_0000_0000, 1, 0);
    rd("R4", 8'h06);
    // R5: writes with either chip enable inactive must not store
    cyc("R5", 1, 1, 1, 0, 4'h0, 8'h05, 36'h0_1111_1111, 1, 0);
    cyc("R5", 0, 0, 1, 0, 4'h0, 8'h05, 36'h0_2222_2222, 1, 0);
    rd("R5", 8'h05);
    // R6: deselect drain
    idle("R6"); idle("R6"); idle("R6"); idle("R6");
    rd("R6", 8'h07);
    idle("R6"); idle("R6"); idle("R6");
    // R7: write right after read drops drivers; write-then-read same address
    rd("R7", 8'h06);
    wr_all("R7", 8'h08, 36'h4_4444_4444);
    rd("R7", 8'h08);
    idle("R7"); idle("R7");
    // R8: oe gating during and after a read
    rd("R8", 8'h05);
    cyc("R8", 1, 1, 0, 0, 4'h0, 8'h00, '0, 0, 0);
    cyc("R8", 1, 1, 0, 0, 4'h0, 8'h00, '0, 1, 0);
    idle("R8");
    rd("R8", 8'h07);
    cyc("R8", 0, 1, 0, 0, 4'h0, 8'h08, '0, 0, 0);
    rd("R8", 8'h06);
    // R9: snooze blocks write and read, contents retained, resumes at once
    cyc("R9", 0, 1, 1, 0, 4'h0, 8'h07, 36'h0_DEAD_BEEF, 1, 1);
    cyc("R9", 0, 1, 0, 0, 4'h0, 8'h05, '0, 1, 1);
    cyc("R9", 0, 1, 0, 0, 4'h0, 8'h05, '0, 1, 1);
    cyc("R9", 0, 1, 0, 0, 4'h0, 8'h05, '0, 1, 1);
    rd("R9", 8'h07);
    wr_all("R9", 8'h09, 36'h5_0505_0505);
    rd("R9", 8'h09);
    // write accepted just before snooze still completes
    wr_all("R9", 8'h0A, 36'h6_0606_0606);
    cyc("R9", 0, 1, 0, 0, 4'h0, 8'h00, '0, 1, 1);
    rd("R9", 8'h0A);
    idle("R9"); idle("R9"); idle("R9");
    repeat (3) @(posedge clk_i);
    #3;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule